// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Service Key

This block is a watchdog for a processor subsystem. Software reaches it through a 32-bit register port with a write strobe and a read strobe. There are two word registers: a control word and a service byte. Once the watchdog is enabled, a first counter runs for a programmed power-of-two number of clock cycles and then raises an interrupt. If software does not service the block after that, a second counter runs for its own programmed period. When it expires, the block issues a system reset request to the power-management logic outside the block.

To service the watchdog, software writes the byte A5h and then the byte 5Ah to the service register. Any other order is ignored. A successful service restarts the first counter, drops the pending interrupt and clears the second counter.

The period codes map to 2^(BASE_EXP - code) cycles. BASE_EXP is 31 in the real system, which gives 2^16 to 2^31 cycles. A smaller BASE_EXP shortens every period by the same factor, so both stages can expire in a short simulation.

Top module: `wdg_timer`

## Requirements
- R1: After reset, both registers read zero, the watchdog is disabled, and `irq` and `rst_req` are low.
- R2: The control word at offset 0x000 holds the interrupt code in bits 3:0, the reset code in bits 7:4, the enable in bit 8, the interrupt enable in bit 9 and the reset enable in bit 10. Bits 31:11 read zero, and any read at an address that is not decoded returns zero.
- R3: With the enable and the interrupt enable set, `irq` rises exactly 2^(BASE_EXP - interrupt code) cycles after the write edge that enabled the block, or after the last successful service.
- R4: With the interrupt enable clear, `irq` stays low. The second stage still starts when the first period expires.
- R5: With the reset enable set, `rst_req` rises 2^(BASE_EXP - reset code) + 1 cycles after the first stage expires, as long as no service occurs in between.
- R6: Once raised, `rst_req` stays high through any service writes. Only clearing the enable or resetting the block lowers it.
- R7: Writing A5h and then 5Ah as the next service write is a service. It drops `irq` on the 5Ah edge and restarts the first period from that edge.
- R8: Writing 5Ah with no A5h just before it, or writing any other value after A5h, is not a service. The first period keeps running.
- R9: Clearing the enable drops `irq` and `rst_req` at once. It also returns both counters to zero, so a later enable times a full period.
- R10: The service register at offset 0x004 reads back the last byte written to it in bits 7:0. Bits 31:8 read zero.
- R11: With the reset enable clear, `rst_req` stays low even after both stages have expired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one write per asserted cycle |
| bus_rd | input | 1 | Read strobe; read data is zero when low |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| irq | output | 1 | First-stage expiry interrupt, level |
| rst_req | output | 1 | Second-stage reset request, held level |

## Verification
The hardest state to reach is second-stage expiry while a service sequence is in progress, and the service that follows it. Reaching it needs the whole first period to pass unserviced, then the whole second period, and then a key pair written after the request has latched. The bench builds the block with BASE_EXP set to 18, so the codes in use give periods of 8 to 128 cycles. Directed sequences drive it past both expiries and then service it to show the request holds. Random runs place a key pair at a random offset within the first period and check the shifted expiry to the exact cycle.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    typedef struct packed {
        logic       rst_en;
        logic       int_en;
        logic       wdt_en;
        logic [3:0] rst_code;
        logic [3:0] int_code;
    } wdg_ctrl_t;

    localparam int CTRL_W = $bits(wdg_ctrl_t);
    localparam int NUM_STAGES = 2;
    localparam int STG_INT = 0;
    localparam int STG_RST = 1;

    localparam logic [7:0] KEY_ARM  = 8'hA5;
    localparam logic [7:0] KEY_FIRE = 8'h5A;

    localparam int CTRL_OFS = 'h000;
    localparam int SVC_OFS  = 'h004;

    function automatic logic [4:0] code_to_exp(input logic [3:0] code, input int base);
        int e;
        e = base - int'(code);
        return e[4:0];
    endfunction

endpackage

// File: rtl/wdg_regs.sv
module wdg_regs
    import wdg_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output wdg_ctrl_t         ctrl,
    output logic [7:0]        svc_byte,
    output logic              svc_wr
);
    logic hit_ctrl, hit_svc;
    logic unused_wdata;

    assign hit_ctrl = (addr == ADDR_W'(CTRL_OFS));
    assign hit_svc  = (addr == ADDR_W'(SVC_OFS));
    assign svc_wr   = wr && hit_svc;
    assign unused_wdata = ^wdata[31:CTRL_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= '0;
            svc_byte <= '0;
        end else if (wr) begin
            if (hit_ctrl) ctrl <= wdg_ctrl_t'(wdata[CTRL_W-1:0]);
            if (hit_svc)  svc_byte <= wdata[7:0];
        end
    end

    always_comb begin
        rdata = '0;
        if (rd) begin
            if (hit_ctrl)     rdata[CTRL_W-1:0] = ctrl;
            else if (hit_svc) rdata[7:0] = svc_byte;
        end
    end
endmodule

// File: rtl/wdg_key.sv
module wdg_key
    import wdg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       svc_wr,
    input  logic [7:0] svc_data,
    output logic       service
);
    logic armed;

    assign service = svc_wr && (svc_data == KEY_FIRE) && armed;

    always_ff @(posedge clk) begin
        if (rst)         armed <= 1'b0;
        else if (svc_wr) armed <= (svc_data == KEY_ARM);
    end
endmodule

// File: rtl/wdg_stage.sv
module wdg_stage #(
    parameter int CNT_W = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       clear,
    input  logic [4:0] exp_sel,
    output logic       done
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;

    assign limit = CNT_W'(1) << exp_sel;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (run && !done) begin
            if (cnt >= limit - CNT_W'(1)) begin
                done <= 1'b1;
                cnt  <= '0;
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/wdg_timer.sv
module wdg_timer
    import wdg_pkg::*;
#(
    parameter int ADDR_W   = 12,
    parameter int BASE_EXP = 31
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq,
    output logic              rst_req
);
    localparam int CNT_W = BASE_EXP + 1;

    wdg_ctrl_t ctrl_q;
    logic [7:0] svc_byte;
    logic       svc_wr, service;
    logic       wdt_en, rst_en, int_done;
    logic       rst_latch;
    logic [NUM_STAGES-1:0] st_run, st_done;
    logic [4:0]            st_exp [NUM_STAGES];

    wdg_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst(rst), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
        .wdata(bus_wdata), .rdata(bus_rdata), .ctrl(ctrl_q),
        .svc_byte(svc_byte), .svc_wr(svc_wr)
    );

    wdg_key u_key (
        .clk(clk), .rst(rst), .svc_wr(svc_wr), .svc_data(bus_wdata[7:0]),
        .service(service)
    );

    assign wdt_en   = ctrl_q.wdt_en;
    assign rst_en   = ctrl_q.rst_en;
    assign int_done = st_done[STG_INT];

    assign st_run[STG_INT] = wdt_en;
    assign st_run[STG_RST] = wdt_en && st_done[STG_INT];
    assign st_exp[STG_INT] = code_to_exp(ctrl_q.int_code, BASE_EXP);
    assign st_exp[STG_RST] = code_to_exp(ctrl_q.rst_code, BASE_EXP);

    for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
        wdg_stage #(.CNT_W(CNT_W)) u_stage (
            .clk(clk), .rst(rst), .run(st_run[g]),
            .clear(!wdt_en || service), .exp_sel(st_exp[g]), .done(st_done[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) rst_latch <= 1'b0;
        else     rst_latch <= (rst_latch || (st_done[STG_RST] && rst_en)) && wdt_en;
    end

    assign irq     = int_done && ctrl_q.int_en && wdt_en;
    assign rst_req = rst_latch && wdt_en;
endmodule

// File: rtl/wdg_timer_chk.sv
module wdg_timer_chk (
    input logic       clk,
    input logic       rst,
    input logic       irq,
    input logic       rst_req,
    input logic       wdt_en,
    input logic       rst_en,
    input logic       int_done,
    input logic       service,
    input logic [7:0] svc_byte
);
    AST_RST_HELD: assert property (@(posedge clk) disable iff (rst) rst_req |=> (rst_req || !wdt_en)); // R6
    AST_RST_AFTER_INT: assert property (@(posedge clk) disable iff (rst) $rose(rst_req) |-> int_done); // R5
    AST_RST_NEEDS_EN: assert property (@(posedge clk) disable iff (rst) $rose(rst_req) |-> rst_en); // R11
    AST_SERVICE_DROPS_IRQ: assert property (@(posedge clk) disable iff (rst) service |=> !irq); // R7
    AST_SERVICE_AFTER_KEY: assert property (@(posedge clk) disable iff (rst) service |-> (svc_byte == 8'hA5)); // R8
    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (rst) !wdt_en |=> !int_done); // R9
endmodule

bind wdg_timer wdg_timer_chk u_chk (
    .clk(clk), .rst(rst), .irq(irq), .rst_req(rst_req), .wdt_en(wdt_en),
    .rst_en(rst_en), .int_done(int_done), .service(service), .svc_byte(svc_byte)
);

// File: tb/test_wdg_timer.sv
module test_wdg_timer;
    localparam int AW = 12;
    localparam int BEXP = 18;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic irq, rst_req;
    int n_chk = 0, n_fail = 0;
    bit done_flag = 0;

    always #2 clk = ~clk;

    wdg_timer #(.ADDR_W(AW), .BASE_EXP(BEXP)) i_wdg_timer (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .rst_req(rst_req)
    );

    function automatic int per(input int code);
        return 1 << (BEXP - code);
    endfunction

    function automatic logic [31:0] ctl(input bit re, input bit ie, input bit en, input int rc, input int ic);
        return (32'(re) << 10) | (32'(ie) << 9) | (32'(en) << 8) | (32'(rc) << 4) | 32'(ic);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = AW'(a);
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd7));
        tick(3);
        rst = 1'b0;
        tick(1);
        // R1 reset state
        rd('h000, d); chk("R1 ctrl", d, 0);
        rd('h004, d); chk("R1 svc", d, 0);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 rst_req", 32'(rst_req), 0);
        // R2 field layout and reserved bits
        wr('h000, 32'hFFFF_F0FF);
        rd('h000, d); chk("R2 readback", d, 32'h0000_00FF);
        wr('h000, 32'hFFFF_FFFF);
        rd('h000, d); chk("R2 reserved", d, 32'h0000_07FF);
        rd('h008, d); chk("R2 undecoded", d, 0);
        wr('h000, 0);
        // R10 service readback
        wr('h004, 32'h1234_56C3);
        rd('h004, d); chk("R10 svc byte", d, 32'h0000_00C3);

        // R8 bad sequences, R3 expiry unaffected
        wr('h000, ctl(0, 1, 1, 15, 11));
        wr('h004, 32'hA5); wr('h004, 32'h00); wr('h004, 32'h5A); wr('h004, 32'h5A);
        tick(per(11) - 1 - 4);
        chk("R8 irq before", 32'(irq), 0);
        tick(1);
        chk("R8 irq at period", 32'(irq), 1);
        wr('h000, 0);

        // R5 then R6 and R9
        wr('h000, ctl(1, 1, 1, 15, 15));
        tick(per(15) - 1); chk("R3 irq before", 32'(irq), 0);
        tick(1);           chk("R3 irq rise", 32'(irq), 1);
        tick(per(15));     chk("R5 rst before", 32'(rst_req), 0);
        tick(1);           chk("R5 rst rise", 32'(rst_req), 1);
        wr('h004, 32'hA5); wr('h004, 32'h5A);
        chk("R7 irq dropped", 32'(irq), 0);
        chk("R6 rst held", 32'(rst_req), 1);
        tick(6);           chk("R6 rst held later", 32'(rst_req), 1);
        wr('h000, 0);
        chk("R9 irq off", 32'(irq), 0);
        chk("R9 rst off", 32'(rst_req), 0);

        // R9 counters held while disabled
        wr('h000, ctl(0, 1, 1, 15, 14));
        tick(10);
        wr('h000, ctl(0, 1, 0, 15, 14));
        tick(20);
        chk("R9 idle irq", 32'(irq), 0);
        wr('h000, ctl(0, 1, 1, 15, 14));
        tick(per(14) - 1); chk("R9 full period", 32'(irq), 0);
        tick(1);           chk("R9 irq after re-enable", 32'(irq), 1);
        wr('h000, 0);

        // R4 interrupt masked, reset stage still runs
        wr('h000, ctl(1, 0, 1, 15, 15));
        tick(per(15));     chk("R4 irq masked", 32'(irq), 0);
        tick(per(15));     chk("R4 rst before", 32'(rst_req), 0);
        tick(1);           chk("R4 rst rise", 32'(rst_req), 1);
        wr('h000, 0);

        // R11 reset request disabled
        wr('h000, ctl(0, 1, 1, 15, 15));
        tick(40);
        chk("R11 no rst", 32'(rst_req), 0);
        chk("R11 irq", 32'(irq), 1);
        wr('h000, 0);

        // random runs, R3/R5/R7
        for (int it = 0; it < 24; it++) begin
            int ic, rc, li, lr, base, a;
            bit ie, re, sv;
            ic = 11 + int'($urandom % 5);
            rc = 11 + int'($urandom % 5);
            ie = 1'($urandom); re = 1'($urandom); sv = 1'($urandom);
            li = per(ic); lr = per(rc);
            wr('h000, 0);
            wr('h000, ctl(re, ie, 1, rc, ic));
            base = 0;
            if (sv) begin
                a = int'($urandom % (li - 2));
                tick(a);
                wr('h004, 32'hA5); wr('h004, 32'h5A);
                base = a + 2;
            end
            tick(base + li - 1 - base);
            chk("R7 irq before", 32'(irq), 0);
            tick(1);
            chk("R3 irq", 32'(irq), 32'(ie));
            tick(lr);
            chk("R5 rst before", 32'(rst_req), 0);
            tick(1);
            chk("R5 rst", 32'(rst_req), 32'(re));
        end
        wr('h000, 0);

        done_flag = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule